// File: doc/BRIEF.md
# USB Endpoint Handshake Status Register

This block is a byte-wide control and status register placed between a small microcontroller core and a USB device controller engine. Firmware reads and writes it through a simple CPU port. The engine drives a few event strobes into it and reads back the flags it needs. The register has three jobs. It reports when the USB bus has gone idle long enough to count as a host suspend. It carries the firmware's request for a remote wakeup. It holds the ownership flags that firmware and the engine use to hand endpoint FIFO buffers back and forth without overwriting each other.

Each bit has its own ownership rule. The transmit-ready flags and the wakeup request can only be set by firmware and can only be cleared by hardware. The EP0 receive flag is set by hardware and can be both set and cleared by firmware. The suspend flag is driven only by a built-in idle timer. When a hardware event and a firmware write hit the same bit in the same cycle, the hardware event wins, so no completion is lost. The idle window is given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `usb_ep_hs_csr`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, every bit of `cpu_rdata` reads 0 and every engine-side output is 0.
- R2: Bits 0, 1 and 4 of `cpu_rdata` always read 0. Firmware writes to bits 0, 1, 2 and 4 change no state.
- R3: Bit 2 (bus suspended) becomes 1 once `bus_act` has been low for IDLE_CYC consecutive clock edges, where IDLE_CYC = CLK_KHZ*IDLE_US/1000. It is still 0 after IDLE_CYC-1 such edges. `bus_suspend` mirrors bit 2.
- R4: A clock edge with `bus_act` high clears bit 2 and restarts the idle count from zero.
- R5: A firmware write with bit 3 = 1 sets the wakeup request (bit 3, mirrored on `remote_wake`). A write with bit 3 = 0 leaves it unchanged.
- R6: The wakeup request is cleared at the first clock edge where `host_susp` is sampled low after having been sampled high. This clear wins over a firmware set in the same cycle.
- R7: A firmware write with bit 5+i = 1 (i = 0 for EP0, i = 1 for EP1) sets transmit-ready flag i, mirrored on `tx_rdy[i]`. A write of 0 to that bit leaves the flag unchanged.
- R8: A pulse on `tx_done[i]` clears transmit-ready flag i at that edge. This clear wins over a firmware set in the same cycle.
- R9: Bit 7 (EP0 receive full, mirrored on `rx0_full`) is set by a pulse on `rx0_done`. A firmware write loads it from bit 7 of the data, so firmware may clear it or set it to lock the engine out. A hardware set wins over a firmware clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_we | input | 1 | Firmware write strobe |
| cpu_wdata | input | 8 | Firmware write data |
| cpu_rdata | output | 8 | Register read value |
| bus_act | input | 1 | Pulse on any USB bus traffic |
| host_susp | input | 1 | Suspend signal level from the engine |
| tx_done | input | NUM_TX_EP | Engine finished reading endpoint i FIFO |
| rx0_done | input | 1 | Engine finished writing EP0 FIFO |
| tx_rdy | output | NUM_TX_EP | Transmit-ready flags to the engine |
| rx0_full | output | 1 | EP0 FIFO owned by firmware; engine must not write |
| remote_wake | output | 1 | Remote wakeup request to the engine |
| bus_suspend | output | 1 | Bus idle suspend indication |

## Verification
Almost every state fault in this register reaches `cpu_rdata` and the matching engine output on the next edge. The bench therefore compares every field against a requirement-level model after every cycle, and a single-cycle deviation is reported at once. An idle counter that is off by one shows up only at the suspend boundary, IDLE_CYC edges after the last bus activity. For that reason both the edge before the boundary and the boundary edge itself are exercised. Lost hardware events can only be seen in cycles where a firmware write hits the same bit, so those collisions are driven on purpose.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
  typedef enum logic [0:0] {
    FLAG_FW_SET_HW_CLR = 1'b0,
    FLAG_HW_SET_FW_RW  = 1'b1
  } flag_mode_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_SUSP = 2;
  localparam int unsigned BIT_WAKE = 3;
  localparam int unsigned BIT_RSVD = 4;
  localparam int unsigned BIT_TX0  = 5;
  localparam int unsigned BIT_RX0  = 7;
endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hs_idle_timer.sv
module hs_idle_timer #(
  parameter int unsigned LIMIT = 36000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_act,
  output logic suspend
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          susp_q, susp_d;

  always_comb begin
    cnt_en = bus_act | (cnt_q != LAST);
    cnt_d  = bus_act ? '0 : cnt_q + 1'b1;
    if (bus_act)             susp_d = 1'b0;
    else if (cnt_q == LAST)  susp_d = 1'b1;
    else                     susp_d = susp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      susp_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      susp_q <= susp_d;
    end
  end

  assign suspend = susp_q;

  assert_act_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |=> (!suspend && cnt_q == '0));
  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_early_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_act && !suspend && cnt_q != LAST) |=> !suspend);
endmodule

// File: rtl/hs_flag_cell.sv
module hs_flag_cell #(
  parameter usb_hs_pkg::flag_mode_e MODE = usb_hs_pkg::FLAG_FW_SET_HW_CLR
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fw_wr,
  input  logic fw_val,
  input  logic hw_evt,
  output logic q
);
  logic q_r, q_n;

  generate
    if (MODE == usb_hs_pkg::FLAG_FW_SET_HW_CLR) begin : g_set_clr
      always_comb begin
        if (hw_evt)               q_n = 1'b0;
        else if (fw_wr && fw_val) q_n = 1'b1;
        else                      q_n = q_r;
      end
      assert_hw_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> !q);
      assert_zero_write_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_wr && !fw_val && !hw_evt) |=> (q == $past(q)));
    end else begin : g_hw_set
      always_comb begin
        if (hw_evt)     q_n = 1'b1;
        else if (fw_wr) q_n = fw_val;
        else            q_n = q_r;
      end
      assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> q);
      assert_fw_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_wr && !hw_evt) |=> (q == $past(fw_val)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_n;
  end

  assign q = q_r;
endmodule

// File: rtl/usb_ep_hs_csr.sv
module usb_ep_hs_csr #(
  parameter int unsigned CLK_KHZ   = 12000,
  parameter int unsigned IDLE_US   = 3000,
  parameter int unsigned NUM_TX_EP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_we,
  input  logic [7:0]           cpu_wdata,
  output logic [7:0]           cpu_rdata,
  input  logic                 bus_act,
  input  logic                 host_susp,
  input  logic [NUM_TX_EP-1:0] tx_done,
  input  logic                 rx0_done,
  output logic [NUM_TX_EP-1:0] tx_rdy,
  output logic                 rx0_full,
  output logic                 remote_wake,
  output logic                 bus_suspend
);
  import usb_hs_pkg::*;

  localparam int unsigned IDLE_CYC = CLK_KHZ * IDLE_US / 1000;

  logic rst_n_i;
  logic hs_q, hs_fall;
  logic wake_q, susp_q, rx_q;
  logic [NUM_TX_EP-1:0] tx_q;
  logic unused_wbits;

  generate
    if (BIT_TX0 + NUM_TX_EP > BIT_RX0) begin : g_bad_cfg
      initial $error("transmit flags overlap the receive flag");
    end
  endgenerate

  hs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  hs_idle_timer #(.LIMIT(IDLE_CYC)) u_idle (
    .clk(clk), .rst_n(rst_n_i), .bus_act(bus_act), .suspend(susp_q)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) hs_q <= 1'b0;
    else          hs_q <= host_susp;
  end

  assign hs_fall = hs_q & ~host_susp;

  hs_flag_cell #(.MODE(FLAG_FW_SET_HW_CLR)) u_wake (
    .clk(clk), .rst_n(rst_n_i), .fw_wr(cpu_we),
    .fw_val(cpu_wdata[BIT_WAKE]), .hw_evt(hs_fall), .q(wake_q)
  );

  for (genvar i = 0; i < NUM_TX_EP; i++) begin : g_tx
    hs_flag_cell #(.MODE(FLAG_FW_SET_HW_CLR)) u_tx (
      .clk(clk), .rst_n(rst_n_i), .fw_wr(cpu_we),
      .fw_val(cpu_wdata[BIT_TX0 + i]), .hw_evt(tx_done[i]), .q(tx_q[i])
    );
  end

  hs_flag_cell #(.MODE(FLAG_HW_SET_FW_RW)) u_rx0 (
    .clk(clk), .rst_n(rst_n_i), .fw_wr(cpu_we),
    .fw_val(cpu_wdata[BIT_RX0]), .hw_evt(rx0_done), .q(rx_q)
  );

  assign unused_wbits = ^{cpu_wdata[BIT_RSVD], cpu_wdata[BIT_SUSP:0]};

  always_comb begin
    cpu_rdata = '0;
    cpu_rdata[BIT_SUSP] = susp_q;
    cpu_rdata[BIT_WAKE] = wake_q;
    for (int i = 0; i < NUM_TX_EP; i++) cpu_rdata[BIT_TX0 + i] = tx_q[i];
    cpu_rdata[BIT_RX0] = rx_q;
  end

  assign tx_rdy      = tx_q;
  assign rx0_full    = rx_q;
  assign remote_wake = wake_q;
  assign bus_suspend = susp_q;

  assert_wake_clear_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($fell(host_susp) || (hs_q && !host_susp)) |=> !remote_wake);
  assert_wake_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (remote_wake && !hs_fall) |=> remote_wake);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cpu_rdata[BIT_RSVD] == 1'b0 && cpu_rdata[1:0] == 2'b00));
  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rx0_full && !cpu_we) |=> rx0_full);
endmodule

// File: tb/usb_ep_hs_csr_test.sv
module usb_ep_hs_csr_test;
  localparam int KHZ = 20;
  localparam int US  = 3000;
  localparam int L   = KHZ * US / 1000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cpu_we, bus_act, host_susp, rx0_done;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [1:0] tx_done, tx_rdy;
  logic       rx0_full, remote_wake, bus_suspend;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic       m_hs, m_wake, m_rx;
  logic [1:0] m_tx;
  int         m_quiet;

  usb_ep_hs_csr #(.CLK_KHZ(KHZ), .IDLE_US(US), .NUM_TX_EP(2)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .bus_act(bus_act), .host_susp(host_susp),
    .tx_done(tx_done), .rx0_done(rx0_done), .tx_rdy(tx_rdy),
    .rx0_full(rx0_full), .remote_wake(remote_wake), .bus_suspend(bus_suspend)
  );

  function automatic logic exp_susp(int quiet);
    return (quiet >= L);
  endfunction

  function automatic logic [7:0] exp_rdata();
    logic [7:0] r = 8'h00;
    r[2] = exp_susp(m_quiet);
    r[3] = m_wake;
    r[6:5] = m_tx;
    r[7] = m_rx;
    return r;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [7:0] e = exp_rdata();
    chk({cpu_rdata[4], cpu_rdata[1:0]}, 8'h00, "R2 reserved bits");
    chk(cpu_rdata[2], e[2], "R3/R4 suspend bit");
    chk(bus_suspend, e[2], "R3 bus_suspend");
    chk(cpu_rdata[3], e[3], "R5/R6 wake bit");
    chk(remote_wake, e[3], "R5 remote_wake");
    chk(cpu_rdata[6:5], e[6:5], "R7/R8 tx bits");
    chk(tx_rdy, e[6:5], "R7 tx_rdy");
    chk(cpu_rdata[7], e[7], "R9 rx bit");
    chk(rx0_full, e[7], "R9 rx0_full");
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic act,
                      input logic [1:0] txd, input logic rxd, input logic hs);
    logic fall;
    cpu_we = we; cpu_wdata = wd; bus_act = act;
    tx_done = txd; rx0_done = rxd; host_susp = hs;
    @(posedge clk);
    fall = m_hs && !hs;
    m_hs = hs;
    if (fall) m_wake = 1'b0;
    else if (we && wd[3]) m_wake = 1'b1;
    for (int i = 0; i < 2; i++) begin
      if (txd[i]) m_tx[i] = 1'b0;
      else if (we && wd[5+i]) m_tx[i] = 1'b1;
    end
    if (rxd) m_rx = 1'b1;
    else if (we) m_rx = wd[7];
    if (act) m_quiet = 0;
    else if (m_quiet < L + 1000) m_quiet++;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cpu_we = 1'b0; cpu_wdata = 8'h00; bus_act = 1'b1;
    host_susp = 1'b0; tx_done = 2'b00; rx0_done = 1'b0;
    m_hs = 1'b0; m_wake = 1'b0; m_rx = 1'b0; m_tx = 2'b00; m_quiet = 0;
    repeat (3) @(negedge clk);
    chk(cpu_rdata, 8'h00, "R1 rdata in reset");
    chk({tx_rdy, rx0_full, remote_wake, bus_suspend}, 8'h00, "R1 outputs in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 2'b00, 1'b0, 1'b0);
    chk(cpu_rdata, 8'h00, "R1 rdata after release");

    // R2 R5 R7 R9: write all ones, only owned bits take it
    step(1'b1, 8'hFF, 1'b1, 2'b00, 1'b0, 1'b0);
    chk(cpu_rdata, 8'hE8, "R2 write ff");
    // R7: zero write does not clear tx, clears rx, keeps wake
    step(1'b1, 8'h00, 1'b1, 2'b00, 1'b0, 1'b0);
    chk(cpu_rdata, 8'h68, "R7 write 00");
    // R8: done beats simultaneous set
    step(1'b1, 8'h20, 1'b1, 2'b01, 1'b0, 1'b0);
    chk(tx_rdy, 2'b10, "R8 collision");
    step(1'b0, 8'h00, 1'b1, 2'b10, 1'b0, 1'b0);
    chk(tx_rdy, 2'b00, "R8 clear ep1");
    // R9: hw set beats firmware clear
    step(1'b1, 8'h00, 1'b1, 2'b00, 1'b1, 1'b0);
    chk(rx0_full, 1'b1, "R9 collision");
    step(1'b1, 8'h00, 1'b1, 2'b00, 1'b0, 1'b0);
    chk(rx0_full, 1'b0, "R9 fw clear");
    // R6: falling host_susp clears wake even with set
    step(1'b0, 8'h00, 1'b1, 2'b00, 1'b0, 1'b1);
    step(1'b1, 8'h08, 1'b1, 2'b00, 1'b0, 1'b0);
    chk(remote_wake, 1'b0, "R6 fall beats set");
    step(1'b1, 8'h08, 1'b1, 2'b00, 1'b0, 1'b0);
    chk(remote_wake, 1'b1, "R5 set");

    // R3 boundary: quiet for L-1 then L edges
    for (int i = 0; i < L - 1; i++) step(1'b0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0);
    chk(bus_suspend, 1'b0, "R3 one edge early");
    step(1'b0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0);
    chk(bus_suspend, 1'b1, "R3 boundary");
    step(1'b1, 8'h04, 1'b0, 2'b00, 1'b0, 1'b0);
    chk(bus_suspend, 1'b1, "R2 write to bit 2 ignored");
    step(1'b0, 8'h00, 1'b1, 2'b00, 1'b0, 1'b0);
    chk(bus_suspend, 1'b0, "R4 activity clears");

    // random traffic checked every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      logic we, act, rxd, hs;
      logic [1:0] txd;
      logic [7:0] wd;
      we  = ($urandom % 4) == 0;
      wd  = 8'($urandom);
      act = ($urandom % 90) == 0;
      txd = {($urandom % 8) == 0, ($urandom % 8) == 0};
      rxd = ($urandom % 8) == 0;
      hs  = (($urandom % 16) == 0) ? !m_hs : m_hs;
      step(we, wd, act, txd, rxd, hs);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule